// File: doc/BRIEF.md
# Reset Delay and Power Mode Controller

This block sits beside a small processor core and decides when the core may run. A one-shot delay timer, advanced by pulses from a slow dedicated oscillator, holds the core in reset after power becomes good, after a watchdog time-out, or after a stop-mode wake-up when the configuration asks for the delay. Once the programmed number of slow ticks has passed, the core is released. It is then told to fetch from the fixed restart address 000CH.

Two low-power modes are entered on single-cycle requests from the core. HALT removes only the CPU clock enable and leaves the oscillator running. An enabled interrupt ends HALT, and the core is told to resume at the instruction after the HALT. STOP removes the CPU clock enable and the oscillator enable. STOP ends only through the reset paths or through a stop-mode wake-up. With the delay option cleared, that wake-up returns straight to run with a restart indication and skips the delay.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While rst_ni is low, and after it is released, core_reset_o=1, cpu_clk_en_o=0, osc_en_o=1, restart_vec_valid_o=0, resume_o=0 and restart_vec_o=0.
- R2: pwr_ok_i passes through two clock flops before use. While the synchronised level is low, the core is held in reset and the delay count is cleared. The rising edge of the synchronised level starts a new delay.
- R3: core_reset_o falls on the clock edge that samples the DELAY_TICKS-th slow_tick_i high since the last trigger. In that first run cycle, restart_vec_valid_o is 1 for exactly one cycle and restart_vec_o=16'h000C. restart_vec_o is 0 in every other cycle.
- R4: A trigger that arrives while the delay is counting restarts the count from zero. A tick sampled in the same cycle as the trigger is not counted.
- R5: wdt_timeout_i high in any state (run, HALT, STOP or reset wait) enters reset wait on the next edge.
- R6: halt_req_i in run enters HALT: cpu_clk_en_o=0, osc_en_o=1, core_reset_o=0.
- R7: In HALT, irq_i returns to run on the next edge with resume_o high for one cycle and restart_vec_valid_o low. irq_i has no effect in run or in STOP.
- R8: stop_req_i in run enters STOP: cpu_clk_en_o=0, osc_en_o=0. If halt_req_i and stop_req_i are high in the same cycle, STOP is entered.
- R9: In STOP, stop_wake_i with wake_delay_i=1 enters reset wait. With wake_delay_i=0, the block returns to run on the next edge with a restart_vec_valid_o pulse and no delay. stop_wake_i outside STOP has no effect.
- R10: A reset trigger (power-good rise, power-good low or watchdog) in the same cycle as an interrupt in HALT or as a no-delay wake in STOP wins: the next state is reset wait, and neither resume_o nor restart_vec_valid_o pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running control clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slow_tick_i | input | 1 | One-cycle pulse from the slow delay oscillator |
| pwr_ok_i | input | 1 | Asynchronous supply-good level |
| wdt_timeout_i | input | 1 | Watchdog time-out pulse |
| wake_delay_i | input | 1 | 1: stop wake-up runs the reset delay, 0: bypass it |
| stop_wake_i | input | 1 | Stop-mode wake-up event |
| halt_req_i | input | 1 | Enter-HALT request pulse from the core |
| stop_req_i | input | 1 | Enter-STOP request pulse from the core |
| irq_i | input | 1 | Enabled interrupt request |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| osc_en_o | output | 1 | Main oscillator enable |
| core_reset_o | output | 1 | Core held in reset |
| restart_vec_valid_o | output | 1 | One-cycle restart indication |
| restart_vec_o | output | 16 | Restart address, 000CH while valid |
| resume_o | output | 1 | One-cycle resume-after-HALT indication |

## Verification
The collision of interest is a reset trigger landing in the same cycle as a mode exit: a watchdog pulse together with an interrupt while halted, and a watchdog pulse together with a no-delay wake while stopped. Directed sequences place both events on one edge. Long random runs let power-good drops, watchdog pulses, ticks and wake events overlap freely. A cycle-level reference model in the bench, built from the requirements, judges every output after each edge. Reset wait must win, and no resume or restart pulse may appear.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_HALT = 2'd1,
    PM_STOP = 2'd2,
    PM_WAIT = 2'd3
  } pm_state_e;
endpackage

// File: rtl/pmc_pok_sync.sv
module pmc_pok_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic lvl_o,
  output logic rise_o
);
  logic [STAGES-1:0] sr_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sr_q[g] <= 1'b0;
          else         sr_q[g] <= async_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sr_q[g] <= 1'b0;
          else         sr_q[g] <= sr_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sr_q[STAGES-1];

  assign lvl_o  = sr_q[STAGES-1];
  assign rise_o = sr_q[STAGES-1] & ~prev_q;

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o) else $error("rise held"); // R2
endmodule

// File: rtl/pmc_trig.sv
module pmc_trig (
  input  logic pok_lvl_i,
  input  logic pok_rise_i,
  input  logic wdt_i,
  input  logic wake_i,
  input  logic wake_delay_i,
  input  logic in_stop_i,
  output logic restart_o,
  output logic bypass_o
);
  logic wake_in_stop;
  assign wake_in_stop = in_stop_i & wake_i;
  // reset paths outrank every mode exit
  assign restart_o = ~pok_lvl_i | pok_rise_i | wdt_i | (wake_in_stop & wake_delay_i);
  assign bypass_o  = wake_in_stop & ~wake_delay_i & ~restart_o;
endmodule

// File: rtl/pmc_delay_timer.sv
module pmc_delay_timer #(
  parameter int unsigned DELAY_TICKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(DELAY_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(DELAY_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          step;

  assign step   = run_i & tick_i & ~clear_i;
  assign done_o = step & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (done_o)  cnt_q <= '0;
    else if (step)    cnt_q <= cnt_q + 1'b1;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST) else $error("count overflow"); // R3
  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> cnt_q == '0) else $error("clear missed"); // R4
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      restart_i,
  input  logic      bypass_i,
  input  logic      done_i,
  input  logic      halt_req_i,
  input  logic      stop_req_i,
  input  logic      irq_i,
  output pm_state_e state_o,
  output logic      restart_pulse_o,
  output logic      resume_pulse_o
);
  pm_state_e state_q, state_d;
  logic      rs_q, rs_d, rm_q, rm_d;

  always_comb begin
    state_d = state_q;
    rs_d    = 1'b0;
    rm_d    = 1'b0;
    if (restart_i) begin
      state_d = PM_WAIT;
    end else begin
      unique case (state_q)
        PM_WAIT: if (done_i) begin state_d = PM_RUN; rs_d = 1'b1; end
        PM_RUN: begin
          if (stop_req_i)      state_d = PM_STOP;
          else if (halt_req_i) state_d = PM_HALT;
        end
        PM_HALT: if (irq_i) begin state_d = PM_RUN; rm_d = 1'b1; end
        PM_STOP: if (bypass_i) begin state_d = PM_RUN; rs_d = 1'b1; end
        default: state_d = PM_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q <= PM_WAIT;
      rs_q    <= 1'b0;
      rm_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      rs_q    <= rs_d;
      rm_q    <= rm_d;
    end

  assign state_o         = state_q;
  assign restart_pulse_o = rs_q;
  assign resume_pulse_o  = rm_q;

  AST_TRIG_TO_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> state_q == PM_WAIT) else $error("trigger lost"); // R5
  AST_RESUME_FROM_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rm_q |-> $past(state_q) == PM_HALT && state_q == PM_RUN) else $error("bad resume"); // R7
  AST_RESTART_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs_q |-> ($past(state_q) == PM_WAIT || $past(state_q) == PM_STOP)) else $error("bad restart"); // R3
  AST_STOP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PM_RUN && stop_req_i && halt_req_i && !restart_i) |=> state_q == PM_STOP)
    else $error("halt beat stop"); // R8
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int unsigned DELAY_TICKS = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned VEC_W       = 16,
  parameter logic [VEC_W-1:0] RESTART_VEC = VEC_W'(16'h000C)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slow_tick_i,
  input  logic             pwr_ok_i,
  input  logic             wdt_timeout_i,
  input  logic             wake_delay_i,
  input  logic             stop_wake_i,
  input  logic             halt_req_i,
  input  logic             stop_req_i,
  input  logic             irq_i,
  output logic             cpu_clk_en_o,
  output logic             osc_en_o,
  output logic             core_reset_o,
  output logic             restart_vec_valid_o,
  output logic [VEC_W-1:0] restart_vec_o,
  output logic             resume_o
);
  logic      pok_lvl, pok_rise, restart, bypass, done;
  pm_state_e state;
  logic      rs_pulse, rm_pulse;

  pmc_pok_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(pwr_ok_i),
    .lvl_o(pok_lvl), .rise_o(pok_rise)
  );

  pmc_trig i_trig (
    .pok_lvl_i(pok_lvl), .pok_rise_i(pok_rise), .wdt_i(wdt_timeout_i),
    .wake_i(stop_wake_i), .wake_delay_i(wake_delay_i),
    .in_stop_i(state == PM_STOP), .restart_o(restart), .bypass_o(bypass)
  );

  pmc_delay_timer #(.DELAY_TICKS(DELAY_TICKS)) i_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(restart),
    .run_i(state == PM_WAIT), .tick_i(slow_tick_i), .done_o(done)
  );

  pmc_mode_fsm i_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart), .bypass_i(bypass),
    .done_i(done), .halt_req_i(halt_req_i), .stop_req_i(stop_req_i),
    .irq_i(irq_i), .state_o(state), .restart_pulse_o(rs_pulse),
    .resume_pulse_o(rm_pulse)
  );

  assign cpu_clk_en_o        = (state == PM_RUN);
  assign osc_en_o            = (state != PM_STOP);
  assign core_reset_o        = (state == PM_WAIT);
  assign restart_vec_valid_o = rs_pulse;
  assign restart_vec_o       = rs_pulse ? RESTART_VEC : '0;
  assign resume_o            = rm_pulse;

  AST_BYPASS_NO_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass |=> !core_reset_o && restart_vec_valid_o) else $error("bypass delayed"); // R9
  AST_POK_LOW_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pok_lvl |=> core_reset_o) else $error("ran without power"); // R2
  AST_NO_DUAL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(restart_vec_valid_o && resume_o)) else $error("dual pulse"); // R10
endmodule

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
  localparam int D = 16;
  localparam int SW_PM_RUN = 0, SW_HALT = 1, SW_STOP = 2, SW_WAIT = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, pok = 0, wdt = 0, wdel = 1, wake = 0, hreq = 0, sreq = 0, irq = 0;
  logic clk_en, osc_en, core_rst, vvalid, resume;
  logic [15:0] vec;
  int total = 0, bad = 0, cycles = 0;

  always #10 clk = ~clk;

  pwr_mode_ctrl #(.DELAY_TICKS(D)) i_pwr_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .slow_tick_i(tick), .pwr_ok_i(pok),
    .wdt_timeout_i(wdt), .wake_delay_i(wdel), .stop_wake_i(wake),
    .halt_req_i(hreq), .stop_req_i(sreq), .irq_i(irq),
    .cpu_clk_en_o(clk_en), .osc_en_o(osc_en), .core_reset_o(core_rst),
    .restart_vec_valid_o(vvalid), .restart_vec_o(vec), .resume_o(resume)
  );

  // reference model built from the requirements
  logic m_s0, m_s1, m_prev, m_rs, m_rm;
  int   m_st, m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s0 = 0; m_s1 = 0; m_prev = 0; m_st = SW_WAIT; m_cnt = 0; m_rs = 0; m_rm = 0;
    end else begin
      automatic logic rise = m_s1 & ~m_prev;
      automatic logic trig = ~m_s1 | rise | wdt | (m_st == SW_STOP && wake && wdel);
      automatic logic byp  = (m_st == SW_STOP) && wake && !wdel && !trig;
      automatic int   nst  = m_st;
      automatic logic nrs  = 0, nrm = 0;
      if (trig) begin nst = SW_WAIT; m_cnt = 0; end
      else case (m_st)
        SW_WAIT: if (tick) begin
          if (m_cnt == D-1) begin nst = SW_PM_RUN; nrs = 1; m_cnt = 0; end
          else m_cnt++;
        end
        SW_PM_RUN: if (sreq) nst = SW_STOP; else if (hreq) nst = SW_HALT;
        SW_HALT: if (irq) begin nst = SW_PM_RUN; nrm = 1; end
        default: if (byp) begin nst = SW_PM_RUN; nrs = 1; end
      endcase
      m_prev = m_s1; m_s1 = m_s0; m_s0 = pok;
      m_st = nst; m_rs = nrs; m_rm = nrm;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_vec(input logic rs);
    return rs ? 16'h000C : 16'h0000;
  endfunction

  // continuous comparison against the model
  always @(negedge clk) if (rst_n) begin
    chk("R3 core_reset", 16'(core_rst), 16'(m_st == SW_WAIT));
    chk("R6 cpu_clk_en", 16'(clk_en), 16'(m_st == SW_PM_RUN));
    chk("R8 osc_en", 16'(osc_en), 16'(m_st != SW_STOP));
    chk("R3 restart_valid", 16'(vvalid), 16'(m_rs));
    chk("R3 restart_vec", vec, exp_vec(m_rs));
    chk("R7 resume", 16'(resume), 16'(m_rm));
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      bad++;
      $display("FAIL R1 watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin tick = 1; cyc(); tick = 0; cyc(); end
  endtask

  task automatic state3(input string tag, input logic r, input logic c, input logic o);
    chk({tag, " reset"}, 16'(core_rst), 16'(r));
    chk({tag, " clk_en"}, 16'(clk_en), 16'(c));
    chk({tag, " osc_en"}, 16'(osc_en), 16'(o));
  endtask

  task automatic boot();
    cyc(4);
    ticks(D);
    chk("R3 released", 16'(core_rst), 16'h0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    cyc(3);
    state3("R1", 1, 0, 1);
    chk("R1 vec", vec, 16'h0);
    rst_n = 1;
    cyc(5);
    ticks(3);
    state3("R2 pok low", 1, 0, 1);
    pok = 1; cyc(4);
    ticks(D-1);
    chk("R3 before last tick", 16'(core_rst), 16'h1);
    tick = 1; cyc(); tick = 0;
    state3("R3 first run", 0, 1, 1);
    chk("R3 valid", 16'(vvalid), 16'h1);
    chk("R3 vec", vec, 16'h000C);
    cyc();
    chk("R3 valid one cycle", 16'(vvalid), 16'h0);
    // R4: trigger during count, with a tick in the same cycle
    wdt = 1; cyc(); wdt = 0;
    ticks(D-1);
    tick = 1; wdt = 1; cyc(); tick = 0; wdt = 0;
    ticks(D-1);
    chk("R4 restarted count", 16'(core_rst), 16'h1);
    ticks(1);
    chk("R4 released after full delay", 16'(core_rst), 16'h0);
    // R7 irq ignored in run, then HALT and exit
    irq = 1; cyc(); irq = 0;
    chk("R7 irq in run", 16'(resume), 16'h0);
    hreq = 1; cyc(); hreq = 0;
    state3("R6 halt", 0, 0, 1);
    irq = 1; cyc(); irq = 0;
    state3("R7 exit", 0, 1, 1);
    chk("R7 resume", 16'(resume), 16'h1);
    chk("R7 no restart", 16'(vvalid), 16'h0);
    // R8 stop beats halt, irq ignored
    hreq = 1; sreq = 1; cyc(); hreq = 0; sreq = 0;
    state3("R8 stop", 0, 0, 0);
    irq = 1; cyc(); irq = 0;
    state3("R8 irq in stop", 0, 0, 0);
    // R9 bypass wake
    wdel = 0; wake = 1; cyc(); wake = 0;
    state3("R9 bypass", 0, 1, 1);
    chk("R9 restart", vec, 16'h000C);
    wake = 1; cyc(); wake = 0;
    state3("R9 wake in run", 0, 1, 1);
    chk("R9 no restart in run", 16'(vvalid), 16'h0);
    sreq = 1; cyc(); sreq = 0;
    wdel = 1; wake = 1; cyc(); wake = 0;
    state3("R9 delayed wake", 1, 0, 1);
    ticks(D);
    // R5 watchdog out of STOP
    sreq = 1; cyc(); sreq = 0;
    wdt = 1; cyc(); wdt = 0;
    state3("R5 wdt from stop", 1, 0, 1);
    ticks(D);
    // R10 collisions
    hreq = 1; cyc(); hreq = 0;
    irq = 1; wdt = 1; cyc(); irq = 0; wdt = 0;
    state3("R10 wdt vs irq", 1, 0, 1);
    chk("R10 no resume", 16'(resume), 16'h0);
    ticks(D);
    sreq = 1; cyc(); sreq = 0;
    wdel = 0; wake = 1; wdt = 1; cyc(); wake = 0; wdt = 0;
    state3("R10 wdt vs bypass", 1, 0, 1);
    chk("R10 no restart", 16'(vvalid), 16'h0);
    ticks(D);
    // R2 power drop in run
    pok = 0; cyc(3);
    state3("R2 drop", 1, 0, 1);
    pok = 1;
    boot();
    // random phase, judged by the model
    for (int i = 0; i < 30000; i++) begin
      tick = ($urandom % 3) == 0;
      wdt  = ($urandom % 400) == 0;
      hreq = ($urandom % 20) == 0;
      sreq = ($urandom % 30) == 0;
      irq  = ($urandom % 12) == 0;
      wake = ($urandom % 15) == 0;
      if (($urandom % 50) == 0) wdel = ~wdel;
      if (($urandom % 3000) == 0) pok = 0;
      else if (!pok && ($urandom % 8) == 0) pok = 1;
      cyc();
    end
    {tick, wdt, hreq, sreq, irq, wake} = '0;
    cyc(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule